// File: doc/BRIEF.md
# Zero-crossing and soft mute controller

This block sits in a digital audio path and silences a stream of signed samples in three ways. A soft mute lowers a gain toward zero one sample at a time, using a fast or a slow step, and raises it again on release. The request comes from a control bit or from an active-low external pin; either source is enough. A direct mute forces the output to zero at once. A zero-crossing mute waits for the signal to come near zero before it switches, both when it engages and when it lets go. This keeps the cut from landing in the middle of a large swing.

A 7-bit control word is written with a one-cycle strobe. Samples arrive with a valid strobe. Each valid sample produces one registered output sample one clock later. Two status flags report whether the soft-mute gain is below unity and whether the zero-crossing mute is engaged.

Top module: `zc_soft_mute`

## Requirements
- R1: After reset, out_vld, smp_out, sm_active and zc_muted are all 0. The control word is all zeros and the gain is at unity (1024).
- R2: out_vld is high in the cycle after each cycle with smp_vld high. If no mute is active, smp_out then equals the input sample.
- R3: A soft mute is requested when control bit 0 is 1 or when smute_pin_n is low. While it is requested, each valid sample lowers the gain by the step, stopping at 0. The output is (sample × gain) arithmetically shifted right by 10, using the gain after that sample's step. sm_active is high whenever the gain is below 1024.
- R4: Control bit 1 selects the slope. 0 gives a step of 16 per sample, and 1 gives a step of 1 per sample.
- R5: While no soft mute is requested, each valid sample raises the gain by the step, stopping at 1024. When the gain is back at 1024, sm_active returns to 0.
- R6: When control bit 2 (direct mute) is 1, every valid sample produces 0 at the output. Writing a word with bit 2 set also clears the held output in the next cycle, without waiting for a sample.
- R7: When control bit 3 is 1 and the block is not yet muted, zero-crossing mute engages on the first valid sample for which either condition holds: |sample| ≤ threshold, or its sign differs from the previous valid sample. That sample already outputs 0, and zc_muted goes high.
- R8: When control bit 3 is 0 while zero-crossing mute is engaged, the release waits for the next sample meeting the same condition. That sample passes, and zc_muted falls. Until then, output stays 0.
- R9: Control bits 6..5 pick the zero-crossing threshold, which is 1280 shifted right by the field value: 00=1280, 01=640, 10=320, 11=160.
- R10: Writing a word with bit 4 set clears zc_muted and forgets the previous sample sign, at once. The next sample then has no sign to compare with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Input sample valid strobe |
| smp_in | input | 16 | Signed input sample |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_word | input | 7 | Control word (bit fields per R3–R10) |
| smute_pin_n | input | 1 | External soft-mute request, low active |
| out_vld | output | 1 | Output sample valid |
| smp_out | output | 16 | Signed output sample |
| sm_active | output | 1 | Soft-mute gain below unity |
| zc_muted | output | 1 | Zero-crossing mute engaged |

## Verification
The bench builds the block with its default parameters: 16-bit samples, a 10-bit gain fraction, steps of 16 and 1, and a base threshold of 1280.

With a fast step of 16, a full fall to zero and a full return each take only 64 samples, so complete ramps are checked sample by sample. The four thresholds are exact integers, which lets the window edges be hit at exactly the threshold and one unit beyond it. The most negative 16-bit sample is also driven, to exercise the magnitude path at its extreme.

// File: rtl/zsm_pkg.sv
package zsm_pkg;

    // Control word bit positions
    localparam int CB_SM_REQ  = 0;
    localparam int CB_SLOW    = 1;
    localparam int CB_DIRECT  = 2;
    localparam int CB_ZC_ON   = 3;
    localparam int CB_ZC_CLR  = 4;
    localparam int CB_WIN_LO  = 5;
    localparam int CB_WIN_HI  = 6;

    // Persistent control fields (the clear bit is a pulse and is not stored)
    typedef struct packed {
        logic [1:0] win;
        logic       zc_on;
        logic       direct;
        logic       slow;
        logic       sm_req;
    } mute_ctl_t;

    function automatic mute_ctl_t decode_ctl(input logic [6:0] w);
        mute_ctl_t c;
        c.win    = w[CB_WIN_HI:CB_WIN_LO];
        c.zc_on  = w[CB_ZC_ON];
        c.direct = w[CB_DIRECT];
        c.slow   = w[CB_SLOW];
        c.sm_req = w[CB_SM_REQ];
        return c;
    endfunction

endpackage

// File: rtl/zsm_window_det.sv
module zsm_window_det #(
    parameter int DATA_W   = 16,
    parameter int THR_BASE = 1280
) (
    input  logic signed [DATA_W-1:0] sample,
    input  logic [1:0]               win,
    input  logic                     prev_ok,
    input  logic                     prev_sign,
    output logic                     zc_event
);
    localparam int MW = DATA_W + 1;

    logic [MW-1:0] mag;
    logic [MW-1:0] thr;
    logic          in_win;
    logic          sign_flip;

    always_comb begin
        // Magnitude in one extra bit so the most negative value fits
        if (sample[DATA_W-1]) begin
            mag = MW'(0) - {sample[DATA_W-1], sample};
        end else begin
            mag = {1'b0, sample};
        end
        thr       = MW'(THR_BASE >> win);
        in_win    = (mag <= thr);
        sign_flip = prev_ok && (sample[DATA_W-1] != prev_sign);
        zc_event  = in_win || sign_flip;
    end

endmodule

// File: rtl/zsm_gain_ramp.sv
module zsm_gain_ramp #(
    parameter int GAIN_FRAC = 10,
    parameter int FAST_STEP = 16,
    parameter int SLOW_STEP = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic               req,
    input  logic               slow,
    output logic [GAIN_FRAC:0] gain_d,
    output logic [GAIN_FRAC:0] gain_q
);
    localparam int GW = GAIN_FRAC + 1;
    localparam logic [GW-1:0] UNITY = GW'(1) << GAIN_FRAC;
    localparam logic [GW-1:0] STEP_F = GW'(FAST_STEP);
    localparam logic [GW-1:0] STEP_S = GW'(SLOW_STEP);

    logic [GW-1:0] step;
    logic [GW-1:0] headroom;

    always_comb begin
        step     = slow ? STEP_S : STEP_F;
        headroom = UNITY - gain_q;
        gain_d   = gain_q;
        if (step_en) begin
            if (req) begin
                gain_d = (gain_q > step) ? gain_q - step : '0;
            end else begin
                gain_d = (headroom > step) ? gain_q + step : UNITY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q <= UNITY;
        end else begin
            gain_q <= gain_d;
        end
    end

    AST_GAIN_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        gain_q <= UNITY); // R5
    AST_GAIN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && req) |=> (gain_q <= $past(gain_q))); // R3
    AST_GAIN_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !req) |=> (gain_q >= $past(gain_q))); // R5
    AST_GAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(gain_q)); // R3

endmodule

// File: rtl/zsm_scaler.sv
module zsm_scaler #(
    parameter int DATA_W    = 16,
    parameter int GAIN_FRAC = 10
) (
    input  logic signed [DATA_W-1:0] sample,
    input  logic [GAIN_FRAC:0]       gain,
    output logic signed [DATA_W-1:0] scaled
);
    localparam int GW = GAIN_FRAC + 1;
    localparam int PW = DATA_W + GW + 1;

    logic signed [PW-1:0] s_ext;
    logic signed [PW-1:0] g_ext;
    logic signed [PW-1:0] prod;

    always_comb begin
        s_ext  = PW'(sample);
        g_ext  = {{(PW-GW){1'b0}}, gain};
        prod   = s_ext * g_ext;
        scaled = DATA_W'(prod >>> GAIN_FRAC);
    end

endmodule

// File: rtl/zc_soft_mute.sv
module zc_soft_mute #(
    parameter int DATA_W    = 16,
    parameter int GAIN_FRAC = 10,
    parameter int FAST_STEP = 16,
    parameter int SLOW_STEP = 1,
    parameter int THR_BASE  = 1280
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_vld,
    input  logic signed [DATA_W-1:0] smp_in,
    input  logic                     ctl_wr,
    input  logic [6:0]               ctl_word,
    input  logic                     smute_pin_n,
    output logic                     out_vld,
    output logic signed [DATA_W-1:0] smp_out,
    output logic                     sm_active,
    output logic                     zc_muted
);
    import zsm_pkg::*;

    localparam int GW = GAIN_FRAC + 1;
    localparam logic [GW-1:0] UNITY = GW'(1) << GAIN_FRAC;

    typedef struct packed {
        mute_ctl_t          ctl;
        logic               zc_muted;
        logic               prev_ok;
        logic               prev_sign;
        logic               out_vld;
        logic [DATA_W-1:0]  out;
    } state_t;

    state_t s_d, s_q;

    logic                     zc_event;
    logic                     sm_req;
    logic [GW-1:0]            gain_d;
    logic [GW-1:0]            gain_q;
    logic signed [DATA_W-1:0] scaled;

    assign sm_req = s_q.ctl.sm_req || !smute_pin_n;

    zsm_window_det #(
        .DATA_W   (DATA_W),
        .THR_BASE (THR_BASE)
    ) u_win (
        .sample    (smp_in),
        .win       (s_q.ctl.win),
        .prev_ok   (s_q.prev_ok),
        .prev_sign (s_q.prev_sign),
        .zc_event  (zc_event)
    );

    zsm_gain_ramp #(
        .GAIN_FRAC (GAIN_FRAC),
        .FAST_STEP (FAST_STEP),
        .SLOW_STEP (SLOW_STEP)
    ) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (smp_vld),
        .req     (sm_req),
        .slow    (s_q.ctl.slow),
        .gain_d  (gain_d),
        .gain_q  (gain_q)
    );

    zsm_scaler #(
        .DATA_W    (DATA_W),
        .GAIN_FRAC (GAIN_FRAC)
    ) u_scale (
        .sample (smp_in),
        .gain   (gain_d),
        .scaled (scaled)
    );

    always_comb begin
        s_d         = s_q;
        s_d.out_vld = smp_vld;
        if (smp_vld) begin
            // Zero-crossing state moves only toward the requested state, on an event
            if ((s_q.ctl.zc_on != s_q.zc_muted) && zc_event) begin
                s_d.zc_muted = s_q.ctl.zc_on;
            end
            s_d.prev_ok   = 1'b1;
            s_d.prev_sign = smp_in[DATA_W-1];
            // Priority: direct, then zero-crossing gate, then ramped gain
            if (s_q.ctl.direct || s_d.zc_muted) begin
                s_d.out = '0;
            end else begin
                s_d.out = scaled;
            end
        end
        if (ctl_wr) begin
            s_d.ctl = decode_ctl(ctl_word);
            if (ctl_word[CB_ZC_CLR]) begin
                s_d.zc_muted = 1'b0;
                s_d.prev_ok  = 1'b0;
            end
            if (ctl_word[CB_DIRECT]) begin
                s_d.out = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_vld   = s_q.out_vld;
    assign smp_out   = s_q.out;
    assign zc_muted  = s_q.zc_muted;
    assign sm_active = (gain_q != UNITY);

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> out_vld); // R2
    AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> !out_vld); // R2
    AST_DIRECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && s_q.ctl.direct) |=> (smp_out == '0)); // R6
    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_word[CB_DIRECT]) |=> (smp_out == '0)); // R6
    AST_ZC_GATES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !ctl_wr) |=> (!zc_muted || smp_out == '0)); // R7
    AST_ZC_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld && !ctl_wr) |=> $stable(zc_muted)); // R8
    AST_ZC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_word[CB_ZC_CLR]) |=> !zc_muted); // R10

endmodule

// File: tb/zc_soft_mute_tb.sv
module zc_soft_mute_tb;
    localparam int DW = 16;
    localparam int NV = 19;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_vld = 1'b0;
    logic signed [DW-1:0] smp_in = '0;
    logic                 ctl_wr = 1'b0;
    logic [6:0]           ctl_word = '0;
    logic                 smute_pin_n = 1'b1;
    logic                 out_vld;
    logic signed [DW-1:0] smp_out;
    logic                 sm_active;
    logic                 zc_muted;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    zc_soft_mute u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_vld     (smp_vld),
        .smp_in      (smp_in),
        .ctl_wr      (ctl_wr),
        .ctl_word    (ctl_word),
        .smute_pin_n (smute_pin_n),
        .out_vld     (out_vld),
        .smp_out     (smp_out),
        .sm_active   (sm_active),
        .zc_muted    (zc_muted)
    );

    // {control word, expected zc flag, sample, expected output}
    localparam logic [39:0] VEC [NV] = '{
        {7'h00, 1'b0,  16'sd1000,   16'sd1000},
        {7'h00, 1'b0, -16'sd2000,  -16'sd2000},
        {7'h04, 1'b0,  16'sd5000,   16'sd0},
        {7'h00, 1'b0,  16'sd3000,   16'sd3000},
        {7'h08, 1'b0,  16'sd3000,   16'sd3000},
        {7'h08, 1'b1,  16'sd1280,   16'sd0},
        {7'h08, 1'b1,  16'sd30000,  16'sd0},
        {7'h00, 1'b1,  16'sd20000,  16'sd0},
        {7'h00, 1'b0, -16'sd20000, -16'sd20000},
        {7'h68, 1'b0, -16'sd500,   -16'sd500},
        {7'h68, 1'b0, -16'sd161,   -16'sd161},
        {7'h68, 1'b1, -16'sd160,    16'sd0},
        {7'h20, 1'b1, -16'sd641,    16'sd0},
        {7'h20, 1'b0, -16'sd640,   -16'sd640},
        {7'h48, 1'b0, -16'sd321,   -16'sd321},
        {7'h48, 1'b1,  16'sd5000,   16'sd0},
        {7'h18, 1'b0,  16'sd5000,   16'sd5000},
        {7'h00, 1'b0,  16'sd4000,   16'sd4000},
        {7'h00, 1'b0, -16'sd32768, -16'sd32768}
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 1, 3, 17, 18: return "R2";
            2:               return "R6";
            4, 5, 6, 15:     return "R7";
            7, 8:            return "R8";
            16:              return "R10";
            default:         return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [6:0] w);
        @(negedge clk);
        ctl_word = w;
        ctl_wr   = 1'b1;
        @(negedge clk);
        ctl_wr   = 1'b0;
    endtask

    task automatic push(input int s);
        @(negedge clk);
        smp_in  = DW'(s);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        int g;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", int'(out_vld), 0);
        chk("R1", int'(smp_out), 0);
        chk("R1", int'(sm_active), 0);
        chk("R1", int'(zc_muted), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(out_vld), 0);

        // Table of control words and samples
        for (int i = 0; i < NV; i++) begin
            wr_ctl(VEC[i][39:33]);
            push(int'($signed(VEC[i][31:16])));
            chk(tag_of(i), int'(smp_out), int'($signed(VEC[i][15:0])));
            chk(tag_of(i), int'(zc_muted), int'(VEC[i][32]));
            chk("R2", int'(out_vld), 1);
        end
        @(negedge clk);
        chk("R2", int'(out_vld), 0);

        // R6: writing direct mute clears held output without a sample
        push(7000);
        chk("R2", int'(smp_out), 7000);
        wr_ctl(7'h04);
        chk("R6", int'(smp_out), 0);
        wr_ctl(7'h00);

        // R3: fast soft mute from the control bit, full descent
        wr_ctl(7'h01);
        g = 1024;
        for (int k = 0; k < 66; k++) begin
            g = (g > 16) ? g - 16 : 0;
            push(1000);
            chk("R3", int'(smp_out), (1000 * g) >>> 10);
        end
        chk("R3", int'(sm_active), 1);

        // R5: release ramps back up to unity
        wr_ctl(7'h00);
        for (int k = 0; k < 66; k++) begin
            g = (1024 - g > 16) ? g + 16 : 1024;
            push(-3000);
            chk("R5", int'(smp_out), (-3000 * g) >>> 10);
        end
        chk("R5", int'(sm_active), 0);

        // R4: slow slope, requested through the pin
        wr_ctl(7'h02);
        smute_pin_n = 1'b0;
        for (int k = 0; k < 5; k++) begin
            g = g - 1;
            push(-3000);
            chk("R4", int'(smp_out), (-3000 * g) >>> 10);
        end
        chk("R3", int'(sm_active), 1);
        smute_pin_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            g = g + 1;
            push(12345);
            chk("R4", int'(smp_out), (12345 * g) >>> 10);
        end
        chk("R5", int'(sm_active), 0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule